// File: doc/BRIEF.md
# Planar 4:2:0 Capture Writer

This block takes a pixel stream in which every pixel is a 32-bit word carrying alpha, Y, U and V. A start-of-frame flag and an end-of-line flag mark the stream. The block turns the stream into memory write requests for a planar 4:2:0 image. There are three planes. The luma plane holds one byte per pixel. The two chroma planes each hold one byte for every two-by-two block of pixels, so each is a quarter of the luma plane's size. Bytes are gathered into bursts. Each burst leaves on a simple valid/ready request port with its plane, its byte address, a byte count and the bytes themselves.

The line width sets the burst length. Chroma bursts are half as long as luma bursts. A line end flushes any partly filled burst. Horizontal chroma decimation keeps the even pixel of each pair. Vertical decimation has two settings. In the default setting both rows of a pair write the same chroma address, so the odd row's values are the ones left in memory. In the reduction setting, odd rows issue no chroma writes at all. The plane bases can be supplied directly, or derived so that the U plane follows the luma plane and the V plane follows the U plane.

Top module: `yuv420_writer`

## Requirements
- R1: Bits 23:16 of the pixel at row r, column c of a frame are written as one byte to base_Y + r*W + c, where W is the configured width. A pixel with the start-of-frame flag is row 0, column 0.
- R2: Chroma is decimated by two in both directions. For chroma row k = r/2, bits 15:8 of the pixel at the even column 2j go to base_U + k*(W/2) + j, and bits 7:0 of the same pixel go to base_V + k*(W/2) + j. Odd-column chroma is never stored. Bits 31:24 are never stored.
- R3: When the reduction setting is off, both rows of a pair write chroma. After the frame, each chroma byte holds the value from the odd row of its pair. Each chroma plane therefore receives (H/2)*ceil((W/2)/(B/2))*2 requests per frame, where H is the frame height and B is the burst length from R5.
- R4: When the reduction setting is on, odd rows issue no chroma requests. Each chroma plane holds the even-row values and receives (H/2)*ceil((W/2)/(B/2)) requests per frame.
- R5: The luma burst length B is 64 when W is a multiple of 64, else 32 when W is a multiple of 32, else 16 when W is a multiple of 16, and 8 otherwise. Chroma bursts hold up to B/2 bytes. Every luma request starts at an in-row offset that is a multiple of B and carries min(B, W - offset) bytes. Chroma requests follow the same rule with B/2 and W/2.
- R6: The end-of-line flag flushes luma and chroma bursts that are only partly filled, so no request spans two rows.
- R7: While any request is waiting, the pixel-ready output is low. A request that is not accepted keeps its plane, address and byte count unchanged until it is accepted. No pixel is lost under backpressure.
- R8: With automatic placement selected, base_U = base_Y + W*H and base_V = base_U + W*H/4. Otherwise the three configured bases are used.
- R9: After reset no request is valid and the pixel-ready output is high.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWidth | input | W_BITS | Line width in pixels (even, nonzero) |
| cfgHeight | input | H_BITS | Frame height in rows (even) |
| cfgReduce | input | 1 | 1 = skip chroma writes on odd rows |
| cfgAutoBase | input | 1 | 1 = derive chroma plane bases from the luma base |
| cfgBaseY | input | ADDR_W | Luma plane base address |
| cfgBaseU | input | ADDR_W | U plane base address when not derived |
| cfgBaseV | input | ADDR_W | V plane base address when not derived |
| pixValid | input | 1 | Pixel word valid |
| pixReady | output | 1 | Pixel word accepted at this edge if valid |
| pixData | input | 32 | Pixel: alpha 31:24, Y 23:16, U 15:8, V 7:0 |
| pixSof | input | 1 | Pixel is the first of a frame |
| pixEol | input | 1 | Pixel is the last of a line |
| reqValid | output | 1 | Write request valid |
| reqReady | input | 1 | Write request accepted |
| reqPlane | output | 2 | 0 = Y, 1 = U, 2 = V |
| reqAddr | output | ADDR_W | Byte address of the first byte |
| reqBytes | output | 7 | Number of bytes in the request |
| reqData | output | 512 | Request bytes, byte i in bits 8i+7:8i |

## Verification
The assertions assume that a stalled pixel source keeps its word and flags steady until the word is accepted. They also assume that the end-of-line flag arrives exactly every W pixels, that W and H are even, and that configuration changes only between frames. The stimulus keeps to these rules. It holds each pixel until the cycle it is accepted. It derives the end-of-line and start-of-frame flags from the loop indices, and it changes width, height, bases and the reduction setting only after the request port has been idle for several cycles. Idle gaps on the pixel side and random backpressure on the request side vary the timing without breaking these rules.

// File: rtl/yuv420wr_pkg.sv
package yuv420wr_pkg;
  localparam int BURST_MAX = 64;
  localparam int ALIGN_W   = $clog2(BURST_MAX);
  localparam int LEN_W     = ALIGN_W + 1;
  localparam int IDX_W     = ALIGN_W;
  localparam int DATA_W    = BURST_MAX * 8;

  typedef enum logic [1:0] {
    PLANE_Y = 2'd0,
    PLANE_U = 2'd1,
    PLANE_V = 2'd2
  } plane_e;

  typedef struct packed {
    logic   take;
    logic   takeChroma;
    logic   frameStart;
    logic   evenLineEnd;
    logic   oddLineEnd;
    plane_e emitPlane;
  } wrStrobe_t;

  // burst length from the alignment of the line width
  function automatic logic [LEN_W-1:0] burstOf(input logic [ALIGN_W-1:0] low);
    if (low == '0)                   return LEN_W'(BURST_MAX);
    else if (low[ALIGN_W-2:0] == '0) return LEN_W'(BURST_MAX / 2);
    else if (low[ALIGN_W-3:0] == '0) return LEN_W'(BURST_MAX / 4);
    else                             return LEN_W'(BURST_MAX / 8);
  endfunction
endpackage

// File: rtl/yuv420wr_ctrl.sv
module yuv420wr_ctrl
  import yuv420wr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ALIGN_W-1:0] widthLow,
  input  logic               cfgReduce,
  input  logic               pixValid,
  input  logic               pixSof,
  input  logic               pixEol,
  output logic               pixReady,
  output logic               reqValid,
  input  logic               reqReady,
  output logic [LEN_W-1:0]   reqBytes,
  output wrStrobe_t          strobe,
  output logic [IDX_W-1:0]   yIdx,
  output logic [IDX_W-2:0]   cIdx
);
  logic [LEN_W-1:0] burst, yCnt;
  logic [LEN_W-2:0] halfBurst, cCnt;
  logic [2:0]       pend;
  logic             colOdd, rowOdd, colOddEff, rowOddEff;
  logic             accept, takeC, yFull, cFull;
  plane_e           sel;

  always_comb begin
    burst     = burstOf(widthLow);
    halfBurst = burst[LEN_W-1:1];
    colOddEff = pixSof ? 1'b0 : colOdd;
    rowOddEff = pixSof ? 1'b0 : rowOdd;
    pixReady  = (pend == 3'b000);
    reqValid  = (pend != 3'b000);
    accept    = pixValid && pixReady;
    takeC     = accept && !colOddEff && !(cfgReduce && rowOddEff);
    yFull     = (yCnt + 1'b1 == burst) || pixEol;
    cFull     = (takeC && (cCnt + 1'b1 == halfBurst)) ||
                (pixEol && (takeC || cCnt != '0));
    if (pend[0])      sel = PLANE_Y;
    else if (pend[1]) sel = PLANE_U;
    else              sel = PLANE_V;
    reqBytes  = (sel == PLANE_Y) ? yCnt : LEN_W'(cCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      yCnt   <= '0;
      cCnt   <= '0;
      pend   <= '0;
      colOdd <= 1'b0;
      rowOdd <= 1'b0;
    end else if (accept) begin
      yCnt <= yCnt + 1'b1;
      if (takeC) cCnt <= cCnt + 1'b1;
      if (yFull) pend[0]   <= 1'b1;
      if (cFull) pend[2:1] <= 2'b11;
      colOdd <= pixEol ? 1'b0 : !colOddEff;
      rowOdd <= pixEol ? !rowOddEff : rowOddEff;
    end else if (reqValid && reqReady) begin
      case (sel)
        PLANE_Y: begin pend[0] <= 1'b0; yCnt <= '0; end
        PLANE_U: pend[1] <= 1'b0;
        default: begin pend[2] <= 1'b0; cCnt <= '0; end
      endcase
    end
  end

  always_comb begin
    strobe.take        = accept;
    strobe.takeChroma  = takeC;
    strobe.frameStart  = accept && pixSof;
    strobe.evenLineEnd = accept && pixEol && !rowOddEff;
    strobe.oddLineEnd  = accept && pixEol && rowOddEff;
    strobe.emitPlane   = sel;
    yIdx = yCnt[IDX_W-1:0];
    cIdx = cCnt[IDX_W-2:0];
  end
endmodule

// File: rtl/yuv420wr_dp.sv
module yuv420wr_dp
  import yuv420wr_pkg::*;
#(
  parameter int W_BITS = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [IDX_W-1:0]  yIdx,
  input  logic [IDX_W-2:0]  cIdx,
  input  logic [23:0]       pixColour,
  input  logic [W_BITS-2:0] halfWidth,
  input  logic [ADDR_W-1:0] baseY,
  input  logic [ADDR_W-1:0] baseU,
  input  logic [ADDR_W-1:0] baseV,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData
);
  localparam int C_BURST = BURST_MAX / 2;

  logic [BURST_MAX-1:0][7:0]        yBuf;
  logic [1:0][C_BURST-1:0][7:0]     cFlat;
  logic [ADDR_W-1:0] yNext, yBurst, cNext, cLine, cBurst;
  logic [ADDR_W-1:0] yPos, cPos, cLineEff, cLineNext;

  always_comb begin
    yPos      = strobe.frameStart ? '0 : yNext;
    cPos      = strobe.frameStart ? '0 : cNext;
    cLineEff  = strobe.frameStart ? '0 : cLine;
    cLineNext = cLineEff + ADDR_W'(halfWidth);
  end

  always_ff @(posedge clk) begin
    if (strobe.take) yBuf[yIdx] <= pixColour[23:16];
  end

  for (genvar p = 0; p < 2; p++) begin : g_chroma
    logic [C_BURST-1:0][7:0] bufQ;
    always_ff @(posedge clk) begin
      if (strobe.takeChroma) bufQ[cIdx] <= pixColour[15-8*p -: 8];
    end
    assign cFlat[p] = bufQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      yNext  <= '0;
      yBurst <= '0;
      cNext  <= '0;
      cLine  <= '0;
      cBurst <= '0;
    end else begin
      if (strobe.take) begin
        yNext <= yPos + 1'b1;
        if (yIdx == '0) yBurst <= yPos;
      end
      if (strobe.frameStart) cLine <= '0;
      if (strobe.takeChroma) begin
        cNext <= cPos + 1'b1;
        if (cIdx == '0) cBurst <= cPos;
      end
      // even row end: rewind so the odd row lands on the same chroma row
      if (strobe.evenLineEnd) cNext <= cLineEff;
      if (strobe.oddLineEnd) begin
        cLine <= cLineNext;
        cNext <= cLineNext;
      end
    end
  end

  always_comb begin
    case (strobe.emitPlane)
      PLANE_Y: begin reqAddr = baseY + yBurst; reqData = yBuf; end
      PLANE_U: begin reqAddr = baseU + cBurst; reqData = DATA_W'(cFlat[0]); end
      default: begin reqAddr = baseV + cBurst; reqData = DATA_W'(cFlat[1]); end
    endcase
  end
endmodule

// File: rtl/yuv420_writer.sv
module yuv420_writer
  import yuv420wr_pkg::*;
#(
  parameter int W_BITS = 8,
  parameter int H_BITS = 8,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [W_BITS-1:0]   cfgWidth,
  input  logic [H_BITS-1:0]   cfgHeight,
  input  logic                cfgReduce,
  input  logic                cfgAutoBase,
  input  logic [ADDR_W-1:0]   cfgBaseY,
  input  logic [ADDR_W-1:0]   cfgBaseU,
  input  logic [ADDR_W-1:0]   cfgBaseV,
  input  logic                pixValid,
  output logic                pixReady,
  input  logic [31:0]         pixData,
  input  logic                pixSof,
  input  logic                pixEol,
  output logic                reqValid,
  input  logic                reqReady,
  output logic [1:0]          reqPlane,
  output logic [ADDR_W-1:0]   reqAddr,
  output logic [LEN_W-1:0]    reqBytes,
  output logic [DATA_W-1:0]   reqData
);
  wrStrobe_t          strobe;
  logic [IDX_W-1:0]   yIdx;
  logic [IDX_W-2:0]   cIdx;
  logic [ADDR_W-1:0]  lumaArea, baseU, baseV;

  always_comb begin
    lumaArea = ADDR_W'(cfgWidth) * ADDR_W'(cfgHeight);
    baseU    = cfgAutoBase ? cfgBaseY + lumaArea : cfgBaseU;
    baseV    = cfgAutoBase ? baseU + (lumaArea >> 2) : cfgBaseV;
    reqPlane = strobe.emitPlane;
  end

  yuv420wr_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .widthLow (cfgWidth[ALIGN_W-1:0]),
    .cfgReduce(cfgReduce),
    .pixValid (pixValid),
    .pixSof   (pixSof),
    .pixEol   (pixEol),
    .pixReady (pixReady),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .reqBytes (reqBytes),
    .strobe   (strobe),
    .yIdx     (yIdx),
    .cIdx     (cIdx)
  );

  yuv420wr_dp #(.W_BITS(W_BITS), .ADDR_W(ADDR_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .yIdx     (yIdx),
    .cIdx     (cIdx),
    .pixColour(pixData[23:0]),
    .halfWidth(cfgWidth[W_BITS-1:1]),
    .baseY    (cfgBaseY),
    .baseU    (baseU),
    .baseV    (baseV),
    .reqAddr  (reqAddr),
    .reqData  (reqData)
  );
endmodule

// File: rtl/yuv420wr_chk.sv
module yuv420wr_chk #(
  parameter int W_BITS = 8,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [W_BITS-1:0] cfgWidth,
  input logic [ADDR_W-1:0] cfgBaseY,
  input logic              pixValid,
  input logic              pixReady,
  input logic [31:0]       pixData,
  input logic              pixEol,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqPlane,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [6:0]        reqBytes
);
  int w, lumaBurst, rowOff;
  always_comb begin
    w = int'(cfgWidth);
    if (w % 64 == 0)      lumaBurst = 64;
    else if (w % 32 == 0) lumaBurst = 32;
    else if (w % 16 == 0) lumaBurst = 16;
    else                  lumaBurst = 8;
    rowOff = (w == 0) ? 0 : int'(reqAddr - cfgBaseY) % w;
  end

  AST_STALL_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !pixReady); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqBytes) && $stable(reqPlane)); // R7

  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pixValid && !pixReady |=> pixValid && $stable(pixData) && $stable(pixEol)); // R7

  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqBytes != 0 &&
      int'(reqBytes) <= ((reqPlane == 2'd0) ? lumaBurst : lumaBurst / 2)); // R5

  AST_LUMA_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqPlane == 2'd0 && w != 0 |-> rowOff % lumaBurst == 0); // R5
endmodule

bind yuv420_writer yuv420wr_chk #(.W_BITS(W_BITS), .ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .cfgWidth(cfgWidth),
  .cfgBaseY(cfgBaseY),
  .pixValid(pixValid),
  .pixReady(pixReady),
  .pixData (pixData),
  .pixEol  (pixEol),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .reqPlane(reqPlane),
  .reqAddr (reqAddr),
  .reqBytes(reqBytes)
);

// File: tb/yuv420_writer_tb_top.sv
module yuv420_writer_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [7:0]   cfgWidth = 8'd8, cfgHeight = 8'd4;
  logic         cfgReduce = 1'b0, cfgAutoBase = 1'b0;
  logic [31:0]  cfgBaseY = 0, cfgBaseU = 0, cfgBaseV = 0;
  logic         pixValid = 1'b0, pixSof = 1'b0, pixEol = 1'b0;
  logic [31:0]  pixData = 0;
  logic         pixReady, reqValid;
  logic         reqReady = 1'b0;
  logic [1:0]   reqPlane;
  logic [31:0]  reqAddr;
  logic [6:0]   reqBytes;
  logic [511:0] reqData;

  always #2.5 clk = ~clk;

  yuv420_writer dut_i (
    .clk(clk), .rstN(rstN), .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .cfgReduce(cfgReduce), .cfgAutoBase(cfgAutoBase), .cfgBaseY(cfgBaseY),
    .cfgBaseU(cfgBaseU), .cfgBaseV(cfgBaseV), .pixValid(pixValid),
    .pixReady(pixReady), .pixData(pixData), .pixSof(pixSof), .pixEol(pixEol),
    .reqValid(reqValid), .reqReady(reqReady), .reqPlane(reqPlane),
    .reqAddr(reqAddr), .reqBytes(reqBytes), .reqData(reqData)
  );

  int errors = 0, checks = 0;
  int W, H, B, seed;
  bit red, autoB;
  int bY, bU, bV;
  logic [7:0] mem [0:4095];
  int yReqs, uReqs, vReqs, shapeErr, stallErr, holdErr, readyPct;
  bit prevWait;
  logic [31:0] prevAddr;
  logic [6:0]  prevBytes;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] yOf(input int r, input int c);
    return 8'((r * 37 + c * 5 + seed * 11) & 255);
  endfunction
  function automatic logic [7:0] uOf(input int r, input int c);
    return 8'((r * 71 + c * 3 + seed * 7 + 9) & 255);
  endfunction
  function automatic logic [7:0] vOf(input int r, input int c);
    return 8'((r * 13 + c * 29 + seed + 100) & 255);
  endfunction
  function automatic int burstFor(input int w);
    if (w % 64 == 0) return 64;
    if (w % 32 == 0) return 32;
    if (w % 16 == 0) return 16;
    return 8;
  endfunction

  // request consumer with random backpressure
  always begin
    @(negedge clk);
    reqReady = rstN && (($urandom % 100) < readyPct);
    #1;
    if (rstN) begin
      if (reqValid && pixReady) stallErr++;
      if (prevWait && (!reqValid || reqAddr != prevAddr || reqBytes != prevBytes)) holdErr++;
      prevWait  = reqValid && !reqReady;
      prevAddr  = reqAddr;
      prevBytes = reqBytes;
      if (reqValid && reqReady) begin
        int off, col, lim, rowLen, base;
        if (reqPlane == 2'd0) begin base = bY; lim = B; rowLen = W; yReqs++; end
        else begin
          base = (reqPlane == 2'd1) ? bU : bV; lim = B / 2; rowLen = W / 2;
          if (reqPlane == 2'd1) uReqs++; else vReqs++;
        end
        off = int'(reqAddr) - base;
        col = off % rowLen;
        if (off < 0 || col % lim != 0 ||
            int'(reqBytes) != ((rowLen - col < lim) ? rowLen - col : lim)) shapeErr++;
        for (int i = 0; i < int'(reqBytes); i++)
          mem[(int'(reqAddr) + i) & 4095] = reqData[i*8 +: 8];
      end
    end
  end

  task automatic runFrame(input int w, input int h, input bit rd, input bit au);
    int nb, expC, mY, mU, mV, aY, eY, aU, eU, aV, eV;
    W = w; H = h; red = rd; autoB = au; B = burstFor(w); seed++;
    bY = au ? 200 : 64;
    bU = au ? bY + w * h : 1600;
    bV = au ? bU + w * h / 4 : 2400;
    for (int i = 0; i < 4096; i++) mem[i] = 8'hEE;
    @(negedge clk);
    cfgWidth = 8'(w); cfgHeight = 8'(h); cfgReduce = rd; cfgAutoBase = au;
    cfgBaseY = 32'(bY); cfgBaseU = au ? 32'd3000 : 32'(bU); cfgBaseV = au ? 32'd3500 : 32'(bV);
    yReqs = 0; uReqs = 0; vReqs = 0; shapeErr = 0; stallErr = 0; holdErr = 0;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        @(negedge clk);
        if ($urandom % 4 == 0) begin pixValid = 1'b0; @(negedge clk); end
        pixValid = 1'b1;
        pixData  = {8'h5A, yOf(r, c), uOf(r, c), vOf(r, c)};
        pixSof   = (r == 0 && c == 0);
        pixEol   = (c == w - 1);
        #1;
        while (!pixReady) begin @(negedge clk); #1; end
        @(posedge clk);
      end
    @(negedge clk);
    pixValid = 1'b0; pixSof = 1'b0; pixEol = 1'b0;
    begin
      int idle = 0;
      while (idle < 8) begin @(negedge clk); #2; if (reqValid) idle = 0; else idle++; end
    end
    mY = 0; mU = 0; mV = 0; aY = 0; eY = 0; aU = 0; eU = 0; aV = 0; eV = 0;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        if (mem[bY + r * w + c] !== yOf(r, c)) begin
          if (mY == 0) begin aY = int'(mem[bY + r * w + c]); eY = int'(yOf(r, c)); end
          mY++;
        end
    for (int k = 0; k < h / 2; k++)
      for (int j = 0; j < w / 2; j++) begin
        int src = rd ? 2 * k : 2 * k + 1;
        if (mem[bU + k * (w / 2) + j] !== uOf(src, 2 * j)) begin
          if (mU == 0) begin aU = int'(mem[bU + k * (w / 2) + j]); eU = int'(uOf(src, 2 * j)); end
          mU++;
        end
        if (mem[bV + k * (w / 2) + j] !== vOf(src, 2 * j)) begin
          if (mV == 0) begin aV = int'(mem[bV + k * (w / 2) + j]); eV = int'(vOf(src, 2 * j)); end
          mV++;
        end
      end
    check(mY == 0, "R1", $sformatf("luma plane w=%0d auto=%0d (first byte)", w, au), aY, eY);
    check(mU == 0, rd ? "R2/R4" : "R2/R3",
          $sformatf("U plane w=%0d reduce=%0d auto=%0d R8", w, rd, au), aU, eU);
    check(mV == 0, rd ? "R2/R4" : "R2/R3",
          $sformatf("V plane w=%0d reduce=%0d auto=%0d R8", w, rd, au), aV, eV);
    check(shapeErr == 0, (w % B != 0 || (w / 2) % (B / 2) != 0) ? "R5/R6" : "R5",
          $sformatf("burst shape w=%0d bad requests", w), shapeErr, 0);
    nb   = ((w / 2) + (B / 2) - 1) / (B / 2);
    expC = (h / 2) * nb * (rd ? 1 : 2);
    check(uReqs == expC && vReqs == expC, rd ? "R4" : "R3",
          $sformatf("chroma request count w=%0d", w), uReqs, expC);
    check(yReqs == h * ((w + B - 1) / B), "R6",
          $sformatf("luma request count w=%0d", w), yReqs, h * ((w + B - 1) / B));
    check(stallErr == 0 && holdErr == 0, "R7",
          $sformatf("backpressure violations w=%0d", w), stallErr + holdErr, 0);
  endtask

  initial begin
    int widths [9] = '{2, 8, 12, 16, 24, 32, 36, 48, 64};
    readyPct = 60; seed = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(!reqValid, "R9", "request valid after reset", int'(reqValid), 0);
    check(pixReady, "R9", "pixel ready after reset", int'(pixReady), 1);
    for (int i = 0; i < 9; i++)
      for (int rd = 0; rd < 2; rd++) begin
        readyPct = (i % 3 == 0) ? 100 : 45;
        runFrame(widths[i], (i % 2 == 0) ? 4 : 6, rd[0], (i + rd) % 2 == 1);
      end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule